// File: doc/BRIEF.md
# Identifier-Dispatched Function-Unit Execute Stage

This block is the execute stage of a small stack processor whose operations are not built into an ALU. A single trigger opcode carries a numeric identifier. The identifier selects one of several external function units. Each unit takes its operands from the top of an internal data stack. It hands back up to two results, and the stage pushes them onto that stack. A unit is either short or long. A short unit completes in the cycle it is started. A long unit runs for as long as it needs and reports completion with a done pulse. While a long unit runs, the stage stalls the upstream pipeline.

A per-identifier redirect table can be written at run time. Once an identifier is redirected, invoking it no longer starts hardware. The stage instead emits a procedure call to a software routine, along with the return address. Rewriting the entry moves the identifier to another routine. Clearing the entry hands the identifier back to its unit.

For each identifier, a parameter table gives four things: whether a unit is attached, whether it is long, how many operands it pops and how many results it pushes (0 to 2). The default table is:

| id | unit | pops | pushes |
|----|------|------|--------|
| 0 | short | 0 | 1 |
| 1 | short | 2 | 1 |
| 2 | short | 1 | 2 |
| 3 | long | 2 | 1 |
| 4 | long | 1 | 0 |
| 5 | short | 2 | 2 |
| 6 | none | – | – |
| 7 | none | – | – |

The default stack holds 4 entries of 16 bits.

Top module: `ipd_dispatch`

## Requirements
- R1: An instruction is a trigger only when `inst_valid` is high and `inst_op` equals 4'hA. The identifier is `inst_id`. Any other opcode starts no unit, raises no flag and leaves the stack unchanged.
- R2: A short invocation that is accepted raises bit `id` of `unit_start` alone, in that same cycle. It never raises `stall`.
- R3: At the clock edge where an invocation completes, the stack depth becomes depth − pops + pushes. The popped entries are removed first. Then `unit_res_lo[id]` is pushed, and, for two pushes, `unit_res_hi[id]` is pushed above it. `opnd_a` shows the top entry and `opnd_b` the one below it; an absent entry reads as 0.
- R4: An accepted long invocation pulses its `unit_start` bit for one cycle. From the next cycle, `stall` is high and the stack does not change. The stack commits at the edge where `unit_done[id]` is high. `stall` is low in the following cycle.
- R5: A `unit_done` bit from any other unit, or any `unit_done` bit while no long invocation is pending, has no effect.
- R6: While `stall` is high, presented instructions are ignored: no start, no call, no flag and no stack change.
- R7: A table write (`tbl_we`) sets the entry `tbl_id` to `tbl_valid`/`tbl_target` and is effective from the next cycle. A later write replaces the target. Writing `tbl_valid`=0 returns the identifier to its unit.
- R8: A trigger on a redirected identifier raises `call_valid` with `call_target` = the entry's target and `call_return` = `inst_pc`+1. It starts no unit and leaves the stack unchanged. A redirect wins over an absent unit.
- R9: A trigger on an identifier with no unit and no redirect raises `illegal_id` for that cycle and is otherwise a no-op.
- R10: If depth < pops, or depth − pops + pushes > stack capacity, `stack_err` is raised for that cycle, no unit starts and the stack is unchanged.
- R11: After reset the depth is 0, `stall` is low, both operand outputs read 0 and no identifier is redirected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Instruction present |
| inst_op | input | 4 | Opcode field |
| inst_id | input | 3 | Function-unit identifier |
| inst_pc | input | 8 | Address of the instruction |
| stall | output | 1 | Hold upstream stages |
| unit_start | output | 8 | One-hot start per unit |
| unit_done | input | 8 | Completion per long unit |
| unit_res_lo | input | 8x16 | First result per unit |
| unit_res_hi | input | 8x16 | Second result per unit |
| opnd_a | output | 16 | Top of stack |
| opnd_b | output | 16 | Entry below the top |
| stack_depth | output | 3 | Number of stack entries |
| tbl_we | input | 1 | Redirect table write |
| tbl_id | input | 3 | Entry to write |
| tbl_valid | input | 1 | Redirect enable value |
| tbl_target | input | 8 | Routine address value |
| call_valid | output | 1 | Redirected dispatch becomes a call |
| call_target | output | 8 | Routine address |
| call_return | output | 8 | Return address |
| illegal_id | output | 1 | Identifier has no unit |
| stack_err | output | 1 | Operand or capacity fault |

## Verification
The hardest situation to reach is a pending long invocation that receives distractions. These are a done pulse from a different long unit and a fresh trigger, both arriving while the stall holds. The bench starts a long unit and waits inside the stalled window. It first pulses the done line of the other long unit, then presents a short trigger. It checks that nothing starts and that the depth and top entries stay frozen. Only after that does it release the correct done. The stack-fault edges also need the stack deliberately filled to capacity and drained below an operand count, so the bench sequences pushes to reach exactly those depths.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    localparam int CNT_W = 2;

    typedef struct packed {
        logic             present;
        logic             is_long;
        logic [CNT_W-1:0] pops;
        logic [CNT_W-1:0] pushes;
    } unit_attr_t;

    typedef enum logic [2:0] {
        DK_NONE,
        DK_SHORT,
        DK_LONG,
        DK_CALL,
        DK_ABSENT,
        DK_STACK
    } disp_kind_t;

    function automatic unit_attr_t attr_of(input logic present,
                                           input logic is_long,
                                           input logic [CNT_W-1:0] pops,
                                           input logic [CNT_W-1:0] pushes);
        unit_attr_t a;
        a.present = present;
        a.is_long = is_long;
        a.pops    = pops;
        a.pushes  = pushes;
        return a;
    endfunction

endpackage

// File: rtl/ipd_attr_tab.sv
module ipd_attr_tab
    import ipd_pkg::*;
#(
    parameter int                      N_IDS   = 8,
    parameter int                      ID_W    = 3,
    parameter logic [N_IDS-1:0]        PRESENT = '0,
    parameter logic [N_IDS-1:0]        LONG    = '0,
    parameter logic [N_IDS*CNT_W-1:0]  POPS    = '0,
    parameter logic [N_IDS*CNT_W-1:0]  PUSHES  = '0
) (
    input  logic [ID_W-1:0] rd_id,
    output unit_attr_t      attr
);

    unit_attr_t tab [N_IDS];

    for (genvar g = 0; g < N_IDS; g++) begin : g_ent
        assign tab[g] = attr_of(PRESENT[g], LONG[g],
                                POPS[g*CNT_W +: CNT_W],
                                PUSHES[g*CNT_W +: CNT_W]);
    end

    always_comb begin
        attr = '0;
        for (int i = 0; i < N_IDS; i++) begin
            if (rd_id == ID_W'(i)) attr = tab[i];
        end
    end

endmodule

// File: rtl/ipd_redirect_tab.sv
module ipd_redirect_tab #(
    parameter int N_IDS  = 8,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic [ID_W-1:0]   rd_id,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target
);

    logic [N_IDS-1:0]  valid_q;
    logic [ADDR_W-1:0] tgt_q [N_IDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < N_IDS; i++) tgt_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_IDS; i++) begin
                if (wr_id == ID_W'(i)) begin
                    valid_q[i] <= wr_valid;
                    tgt_q[i]   <= wr_target;
                end
            end
        end
    end

    always_comb begin
        rd_hit    = 1'b0;
        rd_target = '0;
        for (int i = 0; i < N_IDS; i++) begin
            if (rd_id == ID_W'(i)) begin
                rd_hit    = valid_q[i];
                rd_target = tgt_q[i];
            end
        end
    end

endmodule

// File: rtl/ipd_stack.sv
module ipd_stack
    import ipd_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 16,
    parameter int SP_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [CNT_W-1:0]  pop_n,
    input  logic [CNT_W-1:0]  push_n,
    input  logic [DATA_W-1:0] res_lo,
    input  logic [DATA_W-1:0] res_hi,
    output logic [SP_W-1:0]   sp,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic [SP_W-1:0]   base;

    assign base = sp_q - SP_W'(pop_n);
    assign sp   = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit) begin
            sp_q <= base + SP_W'(push_n);
            for (int i = 0; i < DEPTH; i++) begin
                if (push_n >= CNT_W'(1) && SP_W'(i) == base)
                    mem_q[i] <= res_lo;
                if (push_n >= CNT_W'(2) && SP_W'(i) == base + SP_W'(1))
                    mem_q[i] <= res_hi;
            end
        end
    end

    always_comb begin
        tos = '0;
        nos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == SP_W'(i + 1)) tos = mem_q[i];
        end
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (sp_q == SP_W'(i + 2)) nos = mem_q[i];
        end
    end

endmodule

// File: rtl/ipd_decode.sv
module ipd_decode
    import ipd_pkg::*;
#(
    parameter int             OP_W    = 4,
    parameter logic [OP_W-1:0] TRIG_OP = 4'hA,
    parameter int             DEPTH   = 4,
    parameter int             SP_W    = 3
) (
    input  logic            inst_valid,
    input  logic [OP_W-1:0] inst_op,
    input  logic            busy,
    input  logic [SP_W-1:0] sp,
    input  unit_attr_t      attr,
    input  logic            redir_hit,
    output disp_kind_t      kind
);

    localparam int EW = SP_W + 2;

    logic [EW-1:0] sp_x, pop_x, push_x, after_x;
    logic          underflow, overflow, is_trig;

    assign sp_x      = EW'(sp);
    assign pop_x     = EW'(attr.pops);
    assign push_x    = EW'(attr.pushes);
    assign after_x   = sp_x - pop_x + push_x;
    assign underflow = sp_x < pop_x;
    assign overflow  = after_x > EW'(DEPTH);
    assign is_trig   = inst_valid && !busy && (inst_op == TRIG_OP);

    always_comb begin
        kind = DK_NONE;
        if (is_trig) begin
            if (redir_hit)                 kind = DK_CALL;
            else if (!attr.present)        kind = DK_ABSENT;
            else if (underflow || overflow) kind = DK_STACK;
            else if (attr.is_long)         kind = DK_LONG;
            else                           kind = DK_SHORT;
        end
    end

endmodule

// File: rtl/ipd_dispatch.sv
module ipd_dispatch
    import ipd_pkg::*;
#(
    parameter int                     N_IDS       = 8,
    parameter int                     DEPTH       = 4,
    parameter int                     DATA_W      = 16,
    parameter int                     ADDR_W      = 8,
    parameter int                     OP_W        = 4,
    parameter logic [OP_W-1:0]        TRIG_OP     = 4'hA,
    parameter logic [N_IDS-1:0]       UNIT_PRESENT = 8'b0011_1111,
    parameter logic [N_IDS-1:0]       UNIT_LONG    = 8'b0001_1000,
    parameter logic [N_IDS*CNT_W-1:0] UNIT_POPS    = 16'h0998,
    parameter logic [N_IDS*CNT_W-1:0] UNIT_PUSHES  = 16'h0865,
    localparam int                    ID_W        = $clog2(N_IDS),
    localparam int                    SP_W        = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          inst_valid,
    input  logic [OP_W-1:0]               inst_op,
    input  logic [ID_W-1:0]               inst_id,
    input  logic [ADDR_W-1:0]             inst_pc,
    output logic                          stall,
    output logic [N_IDS-1:0]              unit_start,
    input  logic [N_IDS-1:0]              unit_done,
    input  logic [N_IDS-1:0][DATA_W-1:0]  unit_res_lo,
    input  logic [N_IDS-1:0][DATA_W-1:0]  unit_res_hi,
    output logic [DATA_W-1:0]             opnd_a,
    output logic [DATA_W-1:0]             opnd_b,
    output logic [SP_W-1:0]               stack_depth,
    input  logic                          tbl_we,
    input  logic [ID_W-1:0]               tbl_id,
    input  logic                          tbl_valid,
    input  logic [ADDR_W-1:0]             tbl_target,
    output logic                          call_valid,
    output logic [ADDR_W-1:0]             call_target,
    output logic [ADDR_W-1:0]             call_return,
    output logic                          illegal_id,
    output logic                          stack_err
);

    logic              busy_q;
    logic [ID_W-1:0]   busy_id_q;
    unit_attr_t        inst_attr, busy_attr, commit_attr;
    disp_kind_t        kind;
    logic              redir_hit;
    logic [ID_W-1:0]   sel_id;
    logic [DATA_W-1:0] sel_lo, sel_hi;
    logic              done_sel, commit;

    ipd_attr_tab #(
        .N_IDS(N_IDS), .ID_W(ID_W), .PRESENT(UNIT_PRESENT), .LONG(UNIT_LONG),
        .POPS(UNIT_POPS), .PUSHES(UNIT_PUSHES)
    ) u_attr_inst (
        .rd_id (inst_id),
        .attr  (inst_attr)
    );

    ipd_attr_tab #(
        .N_IDS(N_IDS), .ID_W(ID_W), .PRESENT(UNIT_PRESENT), .LONG(UNIT_LONG),
        .POPS(UNIT_POPS), .PUSHES(UNIT_PUSHES)
    ) u_attr_busy (
        .rd_id (busy_id_q),
        .attr  (busy_attr)
    );

    ipd_redirect_tab #(
        .N_IDS(N_IDS), .ID_W(ID_W), .ADDR_W(ADDR_W)
    ) u_redir (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (tbl_we),
        .wr_id     (tbl_id),
        .wr_valid  (tbl_valid),
        .wr_target (tbl_target),
        .rd_id     (inst_id),
        .rd_hit    (redir_hit),
        .rd_target (call_target)
    );

    ipd_decode #(
        .OP_W(OP_W), .TRIG_OP(TRIG_OP), .DEPTH(DEPTH), .SP_W(SP_W)
    ) u_dec (
        .inst_valid (inst_valid),
        .inst_op    (inst_op),
        .busy       (busy_q),
        .sp         (stack_depth),
        .attr       (inst_attr),
        .redir_hit  (redir_hit),
        .kind       (kind)
    );

    // Result and completion selection: pending long unit owns the bus.
    always_comb begin
        sel_id   = busy_q ? busy_id_q : inst_id;
        sel_lo   = '0;
        sel_hi   = '0;
        done_sel = 1'b0;
        for (int i = 0; i < N_IDS; i++) begin
            if (sel_id == ID_W'(i)) begin
                sel_lo = unit_res_lo[i];
                sel_hi = unit_res_hi[i];
            end
            if (busy_q && busy_id_q == ID_W'(i) && unit_done[i]) done_sel = 1'b1;
        end
    end

    assign commit      = (kind == DK_SHORT) || done_sel;
    assign commit_attr = busy_q ? busy_attr : inst_attr;

    ipd_stack #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .SP_W(SP_W)
    ) u_stack (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .pop_n  (commit_attr.pops),
        .push_n (commit_attr.pushes),
        .res_lo (sel_lo),
        .res_hi (sel_hi),
        .sp     (stack_depth),
        .tos    (opnd_a),
        .nos    (opnd_b)
    );

    always_comb begin
        for (int i = 0; i < N_IDS; i++) begin
            unit_start[i] = ((kind == DK_SHORT) || (kind == DK_LONG)) &&
                            (inst_id == ID_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            busy_id_q <= '0;
        end else if (kind == DK_LONG) begin
            busy_q    <= 1'b1;
            busy_id_q <= inst_id;
        end else if (done_sel) begin
            busy_q    <= 1'b0;
        end
    end

    assign stall       = busy_q;
    assign call_valid  = (kind == DK_CALL);
    assign call_return = inst_pc + ADDR_W'(1);
    assign illegal_id  = (kind == DK_ABSENT);
    assign stack_err   = (kind == DK_STACK);

endmodule

// File: rtl/ipd_dispatch_chk.sv
module ipd_dispatch_chk #(
    parameter int               N_IDS     = 8,
    parameter int               SP_W      = 3,
    parameter int               DEPTH     = 4,
    parameter logic [N_IDS-1:0] LONG_MASK = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             stall,
    input logic [N_IDS-1:0] unit_start,
    input logic [SP_W-1:0]  stack_depth,
    input logic             call_valid,
    input logic             illegal_id,
    input logic             stack_err
);

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(unit_start)); // R2

    AST_SHORT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (|(unit_start & ~LONG_MASK)) |=> !stall); // R2

    AST_LONG_STALLS: assert property (@(posedge clk) disable iff (rst)
        (|(unit_start & LONG_MASK)) |=> stall); // R4

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(stack_depth) || $fell(stall))); // R4

    AST_NO_START_STALLED: assert property (@(posedge clk) disable iff (rst)
        stall |-> (unit_start == '0 && !call_valid && !illegal_id && !stack_err)); // R6

    AST_CALL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        call_valid |-> (unit_start == '0 && !illegal_id && !stack_err)); // R8

    AST_CALL_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (rst)
        call_valid |=> $stable(stack_depth)); // R8

    AST_ABSENT_NOOP: assert property (@(posedge clk) disable iff (rst)
        illegal_id |=> $stable(stack_depth)); // R9

    AST_FAULT_NOOP: assert property (@(posedge clk) disable iff (rst)
        stack_err |-> (unit_start == '0)); // R10

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        stack_depth <= SP_W'(DEPTH)); // R10

endmodule

bind ipd_dispatch ipd_dispatch_chk #(
    .N_IDS(N_IDS), .SP_W(SP_W), .DEPTH(DEPTH), .LONG_MASK(UNIT_LONG)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .unit_start  (unit_start),
    .stack_depth (stack_depth),
    .call_valid  (call_valid),
    .illegal_id  (illegal_id),
    .stack_err   (stack_err)
);

// File: tb/tb_ipd_dispatch.sv
`timescale 1ns/1ps
module tb_ipd_dispatch;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             inst_valid = 1'b0;
    logic [3:0]       inst_op = '0;
    logic [2:0]       inst_id = '0;
    logic [7:0]       inst_pc = '0;
    logic             stall;
    logic [7:0]       unit_start;
    logic [7:0]       unit_done = '0;
    logic [7:0][15:0] res_lo = '0;
    logic [7:0][15:0] res_hi = '0;
    logic [15:0]      opnd_a, opnd_b;
    logic [2:0]       stack_depth;
    logic             tbl_we = 1'b0;
    logic [2:0]       tbl_id = '0;
    logic             tbl_valid = 1'b0;
    logic [7:0]       tbl_target = '0;
    logic             call_valid;
    logic [7:0]       call_target, call_return;
    logic             illegal_id, stack_err;

    always #2 clk = ~clk;

    ipd_dispatch dut (
        .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_op(inst_op),
        .inst_id(inst_id), .inst_pc(inst_pc), .stall(stall),
        .unit_start(unit_start), .unit_done(unit_done),
        .unit_res_lo(res_lo), .unit_res_hi(res_hi),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stack_depth(stack_depth),
        .tbl_we(tbl_we), .tbl_id(tbl_id), .tbl_valid(tbl_valid),
        .tbl_target(tbl_target), .call_valid(call_valid),
        .call_target(call_target), .call_return(call_return),
        .illegal_id(illegal_id), .stack_err(stack_err)
    );

    // Bench knowledge of the default unit table (from the requirements).
    int  b_pres [8] = '{1, 1, 1, 1, 1, 1, 0, 0};
    int  b_pop  [8] = '{0, 2, 1, 2, 1, 2, 0, 0};
    int  b_push [8] = '{1, 1, 2, 1, 0, 2, 0, 0};
    bit  r_v    [8];
    int  r_t    [8];

    int n_checks = 0;
    int n_errors = 0;
    int model[$];
    int pc_ctr = 16;

    typedef struct {
        string req;
        int    depth;
        int    tos;
        int    nos;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push_expect(input string req);
        exp_t e;
        e.req   = req;
        e.depth = model.size();
        e.tos   = (model.size() >= 1) ? model[model.size()-1] : 0;
        e.nos   = (model.size() >= 2) ? model[model.size()-2] : 0;
        exp_q.push_back(e);
    endtask

    // Monitor: compares the stack view against queued expectations.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.req, "depth", 32'(stack_depth), 32'(e.depth));
            chk(e.req, "top", 32'(opnd_a), 32'(e.tos));
            chk(e.req, "below-top", 32'(opnd_b), 32'(e.nos));
            chk(e.req, "stall", 32'(stall), 32'd0);
        end
    end

    task automatic exec(input int id, input logic [15:0] lo, input logic [15:0] hi,
                        input string req);
        logic [7:0] st, ct, cr;
        logic       cv, il, se;
        int         sz;
        bit         fault;
        sz = model.size();
        @(negedge clk);
        inst_valid = 1'b1; inst_op = 4'hA; inst_id = 3'(id); inst_pc = 8'(pc_ctr);
        res_lo[id] = lo; res_hi[id] = hi;
        #1;
        st = unit_start; cv = call_valid; ct = call_target; cr = call_return;
        il = illegal_id; se = stack_err;
        @(posedge clk); #1;
        inst_valid = 1'b0;
        if (r_v[id]) begin
            chk(req, "call_valid", 32'(cv), 32'd1);
            chk(req, "call_target", 32'(ct), 32'(r_t[id]));
            chk(req, "call_return", 32'(cr), 32'((pc_ctr + 1) & 8'hFF));
            chk(req, "start on call", 32'(st), 32'd0);
        end else if (b_pres[id] == 0) begin
            chk(req, "illegal_id", 32'(il), 32'd1);
            chk(req, "start on absent", 32'(st), 32'd0);
        end else begin
            fault = (sz < b_pop[id]) || (sz - b_pop[id] + b_push[id] > 4);
            chk(req, "stack_err", 32'(se), 32'(fault));
            if (fault) begin
                chk(req, "start on fault", 32'(st), 32'd0);
            end else begin
                chk(req, "unit_start", 32'(st), 32'd1 << id);
                chk(req, "no call", 32'(cv), 32'd0);
                repeat (b_pop[id]) void'(model.pop_back());
                if (b_push[id] >= 1) model.push_back(int'(lo));
                if (b_push[id] >= 2) model.push_back(int'(hi));
            end
        end
        push_expect(req);
        pc_ctr++;
    endtask

    task automatic exec_long(input int id, input logic [15:0] lo, input int n);
        int sz;
        int other;
        int old_tos;
        sz = model.size();
        old_tos = (sz >= 1) ? model[sz-1] : 0;
        other = (id == 3) ? 4 : 3;
        @(negedge clk);
        inst_valid = 1'b1; inst_op = 4'hA; inst_id = 3'(id); inst_pc = 8'(pc_ctr);
        res_lo[id] = lo;
        #1;
        chk("R4", "long start", 32'(unit_start), 32'd1 << id);
        @(posedge clk); #1;
        inst_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R4", "stall held", 32'(stall), 32'd1);
            chk("R4", "depth frozen", 32'(stack_depth), 32'(sz));
            chk("R4", "top frozen", 32'(opnd_a), 32'(old_tos));
            if (k == 0) unit_done[other] = 1'b1;          // R5 distraction
            if (k == 1) begin
                unit_done[other] = 1'b0;
                inst_valid = 1'b1; inst_id = 3'd0;        // R6 distraction
                #1;
                chk("R6", "start while stalled", 32'(unit_start), 32'd0);
            end
            if (k == 2) inst_valid = 1'b0;
        end
        @(negedge clk);
        inst_valid = 1'b0;
        chk("R5", "foreign done ignored", 32'(stall), 32'd1);
        unit_done[id] = 1'b1;
        @(posedge clk); #1;
        unit_done[id] = 1'b0;
        repeat (b_pop[id]) void'(model.pop_back());
        if (b_push[id] >= 1) model.push_back(int'(lo));
        push_expect("R4");
        pc_ctr++;
    endtask

    task automatic tbl_write(input int id, input bit v, input int t);
        @(negedge clk);
        tbl_we = 1'b1; tbl_id = 3'(id); tbl_valid = v; tbl_target = 8'(t);
        @(posedge clk); #1;
        tbl_we = 1'b0;
        r_v[id] = v; r_t[id] = t;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin r_v[i] = 1'b0; r_t[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset depth", 32'(stack_depth), 32'd0);
        chk("R11", "reset stall", 32'(stall), 32'd0);
        chk("R11", "reset top", 32'(opnd_a), 32'd0);
        chk("R11", "reset below", 32'(opnd_b), 32'd0);

        exec(0, 16'h0011, 16'h0, "R2");
        exec(0, 16'h0022, 16'h0, "R2");
        exec(1, 16'h0033, 16'h0, "R3");
        exec(2, 16'h0044, 16'h0055, "R3");
        exec(5, 16'h0066, 16'h0077, "R3");
        exec(1, 16'h0088, 16'h0, "R3");
        exec(1, 16'h0099, 16'h0, "R10");   // underflow: one entry, two pops
        exec(0, 16'h00A1, 16'h0, "R2");
        exec(0, 16'h00A2, 16'h0, "R2");
        exec(0, 16'h00A3, 16'h0, "R2");
        exec(0, 16'h00A4, 16'h0, "R10");   // capacity exceeded
        exec(2, 16'h00B1, 16'h00B2, "R10");
        exec(6, 16'h0, 16'h0, "R9");

        // R1: non-trigger opcode has no effect
        @(negedge clk);
        inst_valid = 1'b1; inst_op = 4'h3; inst_id = 3'd0;
        #1;
        chk("R1", "start on other opcode", 32'(unit_start), 32'd0);
        chk("R1", "flags on other opcode", 32'({call_valid, illegal_id, stack_err}), 32'd0);
        @(posedge clk); #1;
        inst_valid = 1'b0;
        push_expect("R1");

        exec_long(3, 16'h0C3C, 5);
        exec_long(4, 16'h0, 3);

        // R5: done while idle
        @(negedge clk);
        res_lo[3] = 16'hDEAD;
        unit_done = 8'hFF;
        @(posedge clk); #1;
        unit_done = '0;
        push_expect("R5");

        tbl_write(1, 1'b1, 8'h40);
        exec(1, 16'h0, 16'h0, "R8");
        tbl_write(1, 1'b1, 8'h80);
        exec(1, 16'h0, 16'h0, "R7");
        tbl_write(6, 1'b1, 8'h20);
        exec(6, 16'h0, 16'h0, "R8");
        tbl_write(1, 1'b0, 8'h00);
        exec(1, 16'h00AB, 16'h0, "R7");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule